// File: doc/BRIEF.md
# Byte-Register I2C Bus Master

This block is an I2C bus master that software drives through six byte-wide registers. Software stores a device address byte in the target register. Bit 0 of that byte is the direction: 0 means write and 1 means read. For a write, software also loads one or two payload bytes. It then writes the control register with the launch bit set. From there the block produces the complete bus sequence on its own: a START, the address byte, the acknowledge slots, one or two data bytes and a closing STOP.

While the sequence runs, the launch bit reads back as 1 and serves as the busy flag. Any register write made in this period is discarded. If the slave answers an acknowledge slot with a high level, an error flag is raised and the transfer is cut short with a STOP. The flag clears again when the next transfer is launched. Bytes read from the slave land in two read-back registers.

The bus pins are modelled as open drain. Each line has an output enable that pulls it low, and SDA is also brought back in as an input. The SCL rate comes from a parameter that sets the number of system clocks in each quarter of an SCL period.

Top module: `i2cm_top`

## Requirements
- R1: After reset, every register reads 0x00 and both output enables (`scl_oe`, `sda_oe`) are 0, which leaves the bus released.
- R2: Writing the control register (offset 5) with bit 1 = 1 while bit 1 reads 0 launches a transfer. Bit 1 reads 1 until the STOP has been sent and 0 afterwards.
- R3: While control bit 1 reads 1, writes to any register have no effect.
- R4: Control bit 0 sets the transfer length. A value of 1 gives two data bytes and a value of 0 gives one.
- R5: The target register (offset 0) goes out first, MSB first, and its bit 0 is the R/W bit. A write then sends data byte 0 (offset 1), followed by data byte 1 (offset 2) when the length is two.
- R6: Control bit 2 is set when the level sampled in any slave acknowledge slot is 1.
- R7: Control bit 2 is cleared when the next transfer is launched.
- R8: After a negative acknowledge, no further bytes are transferred. A STOP follows at once and bit 1 clears.
- R9: In a read, the first received byte goes to offset 3 and the second to offset 4. Offset 4 is written only when the length is two; a one-byte read leaves it unchanged.
- R10: In a read, the master drives ACK (low) after each byte except the last, and leaves NACK (high) after the last byte.
- R11: The SCL period is 4 x QTR_CYCLES clocks. The master changes SDA only while SCL is low, except for the START edge and the STOP edge.
- R12: Both lines are open drain. An output enable of 1 pulls the line low, and an enable of 0 releases it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational on reg_addr) |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_in | input | 1 | Sampled SDA line level |
| sda_oe | output | 1 | Pull SDA low when 1 |

## Verification
The bench builds the block with QTR_CYCLES = 3, so one SCL period takes only 12 clocks. At that rate a whole table of transfers fits in a short run: one- and two-byte writes and reads, a wrong address, and a negative acknowledge in the middle of a write. The bench also measures the SCL period in clocks and compares it exactly against four quarters. A bus model that answers as the slave decodes START and STOP itself, and records every data bit and every master acknowledge it sees.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_START,
        PH_ADDR,
        PH_AACK,
        PH_DATA,
        PH_DACK,
        PH_STOP
    } phase_e;

    localparam int REG_AW = 3;

    localparam logic [REG_AW-1:0] RA_TARGET = 3'd0;
    localparam logic [REG_AW-1:0] RA_WD0    = 3'd1;
    localparam logic [REG_AW-1:0] RA_WD1    = 3'd2;
    localparam logic [REG_AW-1:0] RA_RD0    = 3'd3;
    localparam logic [REG_AW-1:0] RA_RD1    = 3'd4;
    localparam logic [REG_AW-1:0] RA_CTRL   = 3'd5;

    localparam int CB_LEN = 0;
    localparam int CB_GO  = 1;
    localparam int CB_ERR = 2;

    // Transfer request from the register file to the sequencer
    typedef struct packed {
        logic       start;
        logic       two;
        logic [7:0] target;
        logic [7:0] wd0;
        logic [7:0] wd1;
    } job_t;

    // Single-cycle events from the sequencer back to the register file
    typedef struct packed {
        logic       done;
        logic       ack_err;
        logic       rx_valid;
        logic       rx_idx;
        logic [7:0] rx_byte;
    } evt_t;

    // Phases in which SCL toggles as a data/ack clock cell or a STOP cell
    function automatic logic clocked_phase(phase_e p);
        return (p == PH_ADDR) || (p == PH_AACK) || (p == PH_DATA) ||
               (p == PH_DACK) || (p == PH_STOP);
    endfunction

endpackage

// File: rtl/i2cm_qtick.sv
module i2cm_qtick #(
    parameter int QTR_CYCLES = 125
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int CW = (QTR_CYCLES > 2) ? $clog2(QTR_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(QTR_CYCLES - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = run && (cnt == LAST);

endmodule

// File: rtl/i2cm_regs.sv
module i2cm_regs
    import i2cm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  evt_t              evt,
    output job_t              job,
    output logic              busy,
    output logic              err
);
    logic [7:0] target_q, wd0_q, wd1_q, rd0_q, rd1_q;
    logic       len_q, go_q, err_q;
    logic       wr_ok, launch;

    assign wr_ok  = reg_wr && !go_q;
    assign launch = wr_ok && (reg_addr == RA_CTRL) && reg_wdata[CB_GO];

    always_ff @(posedge clk) begin
        if (rst) begin
            target_q <= '0;
            wd0_q    <= '0;
            wd1_q    <= '0;
            rd0_q    <= '0;
            rd1_q    <= '0;
            len_q    <= 1'b0;
            go_q     <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            if (wr_ok) begin
                unique case (reg_addr)
                    RA_TARGET: target_q <= reg_wdata;
                    RA_WD0:    wd0_q    <= reg_wdata;
                    RA_WD1:    wd1_q    <= reg_wdata;
                    RA_CTRL:   len_q    <= reg_wdata[CB_LEN];
                    default:   ;
                endcase
            end
            if (launch) begin
                go_q  <= 1'b1;
                err_q <= 1'b0;
            end
            if (evt.done)    go_q  <= 1'b0;
            if (evt.ack_err) err_q <= 1'b1;
            if (evt.rx_valid) begin
                if (evt.rx_idx) rd1_q <= evt.rx_byte;
                else            rd0_q <= evt.rx_byte;
            end
        end
    end

    always_comb begin
        unique case (reg_addr)
            RA_TARGET: reg_rdata = target_q;
            RA_WD0:    reg_rdata = wd0_q;
            RA_WD1:    reg_rdata = wd1_q;
            RA_RD0:    reg_rdata = rd0_q;
            RA_RD1:    reg_rdata = rd1_q;
            RA_CTRL:   reg_rdata = {5'b0, err_q, go_q, len_q};
            default:   reg_rdata = 8'h00;
        endcase
    end

    assign job.start  = launch;
    assign job.two    = len_q;
    assign job.target = target_q;
    assign job.wd0    = wd0_q;
    assign job.wd1    = wd1_q;
    assign busy       = go_q;
    assign err        = err_q;

endmodule

// File: rtl/i2cm_seq.sv
module i2cm_seq
    import i2cm_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   tick,
    input  job_t   job,
    input  logic   sda_in,
    output phase_e phase,
    output logic   scl_oe,
    output logic   sda_oe,
    output evt_t   evt
);
    phase_e     ph_q;
    logic [1:0] q_q;
    logic [2:0] bit_q;
    logic       bidx_q;
    logic       sda_lo_q;
    logic       nack_q;
    logic [7:0] sh_q;
    evt_t       evt_q;

    logic       rd_mode;
    logic       last_byte;
    logic [7:0] cur_wd;

    assign rd_mode   = job.target[0];
    assign last_byte = bidx_q || !job.two;
    assign cur_wd    = bidx_q ? job.wd1 : job.wd0;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q     <= PH_IDLE;
            q_q      <= 2'd0;
            bit_q    <= 3'd7;
            bidx_q   <= 1'b0;
            sda_lo_q <= 1'b0;
            nack_q   <= 1'b0;
            sh_q     <= '0;
            evt_q    <= '0;
        end else begin
            evt_q <= '0;
            if (ph_q == PH_IDLE) begin
                if (job.start) begin
                    ph_q     <= PH_START;
                    q_q      <= 2'd0;
                    bidx_q   <= 1'b0;
                    sda_lo_q <= 1'b0;
                    nack_q   <= 1'b0;
                end
            end else if (tick) begin
                q_q <= q_q + 2'd1;
                unique case (q_q)
                    // entering quarter 1: SCL is low in every clocked cell
                    2'd0: begin
                        unique case (ph_q)
                            PH_ADDR: sda_lo_q <= ~job.target[bit_q];
                            PH_AACK: sda_lo_q <= 1'b0;
                            PH_DATA: sda_lo_q <= rd_mode ? 1'b0 : ~cur_wd[bit_q];
                            PH_DACK: sda_lo_q <= rd_mode ? !last_byte : 1'b0;
                            PH_STOP: sda_lo_q <= 1'b1;
                            default: ;
                        endcase
                    end
                    // entering quarter 2: SCL high; START edge on SDA
                    2'd1: begin
                        if (ph_q == PH_START) sda_lo_q <= 1'b1;
                    end
                    // middle of the SCL high phase: sample, or STOP edge
                    2'd2: begin
                        unique case (ph_q)
                            PH_DATA: sh_q <= {sh_q[6:0], sda_in};
                            PH_AACK: nack_q <= sda_in;
                            PH_DACK: if (!rd_mode) nack_q <= sda_in;
                            PH_STOP: sda_lo_q <= 1'b0;
                            default: ;
                        endcase
                    end
                    // end of cell: advance
                    default: begin
                        unique case (ph_q)
                            PH_START: begin
                                ph_q  <= PH_ADDR;
                                bit_q <= 3'd7;
                            end
                            PH_ADDR: begin
                                if (bit_q == 3'd0) ph_q  <= PH_AACK;
                                else               bit_q <= bit_q - 3'd1;
                            end
                            PH_AACK: begin
                                if (nack_q) begin
                                    ph_q          <= PH_STOP;
                                    evt_q.ack_err <= 1'b1;
                                end else begin
                                    ph_q  <= PH_DATA;
                                    bit_q <= 3'd7;
                                end
                            end
                            PH_DATA: begin
                                if (bit_q == 3'd0) ph_q  <= PH_DACK;
                                else               bit_q <= bit_q - 3'd1;
                            end
                            PH_DACK: begin
                                if (rd_mode) begin
                                    evt_q.rx_valid <= 1'b1;
                                    evt_q.rx_idx   <= bidx_q;
                                    evt_q.rx_byte  <= sh_q;
                                end
                                if (!rd_mode && nack_q) begin
                                    ph_q          <= PH_STOP;
                                    evt_q.ack_err <= 1'b1;
                                end else if (last_byte) begin
                                    ph_q <= PH_STOP;
                                end else begin
                                    ph_q   <= PH_DATA;
                                    bidx_q <= 1'b1;
                                    bit_q  <= 3'd7;
                                end
                            end
                            PH_STOP: begin
                                ph_q       <= PH_IDLE;
                                evt_q.done <= 1'b1;
                            end
                            default: ph_q <= PH_IDLE;
                        endcase
                    end
                endcase
            end
        end
    end

    assign phase  = ph_q;
    assign scl_oe = clocked_phase(ph_q) && !q_q[1];
    assign sda_oe = sda_lo_q;
    assign evt    = evt_q;

endmodule

// File: rtl/i2cm_top.sv
module i2cm_top
    import i2cm_pkg::*;
#(
    parameter int QTR_CYCLES = 125
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       reg_wr,
    input  logic [2:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       scl_oe,
    input  logic       sda_in,
    output logic       sda_oe
);
    job_t   job;
    evt_t   evt;
    phase_e phase;
    logic   busy;
    logic   err;
    logic   tick;

    i2cm_regs regs_i (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .evt       (evt),
        .job       (job),
        .busy      (busy),
        .err       (err)
    );

    i2cm_qtick #(.QTR_CYCLES(QTR_CYCLES)) qtick_i (
        .clk  (clk),
        .rst  (rst),
        .run  (phase != PH_IDLE),
        .tick (tick)
    );

    i2cm_seq seq_i (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .job    (job),
        .sda_in (sda_in),
        .phase  (phase),
        .scl_oe (scl_oe),
        .sda_oe (sda_oe),
        .evt    (evt)
    );

endmodule

// File: rtl/i2cm_chk.sv
module i2cm_chk
    import i2cm_pkg::*;
(
    input logic   clk,
    input logic   rst,
    input phase_e phase,
    input evt_t   evt,
    input job_t   job,
    input logic   busy,
    input logic   err,
    input logic   scl_oe,
    input logic   sda_oe
);
    AST_BUS_FREE_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE) |-> (!scl_oe && !sda_oe)); // R12

    AST_BUSY_DROPS_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
        evt.done |=> !busy); // R2

    AST_BUSY_HELD_UNTIL_DONE: assert property (@(posedge clk) disable iff (rst)
        (busy && !evt.done) |=> busy); // R2

    AST_REGS_FROZEN_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        busy |=> ($stable(job.target) && $stable(job.wd0) && $stable(job.wd1) && $stable(job.two))); // R3

    AST_ERR_CLEARED_ON_LAUNCH: assert property (@(posedge clk) disable iff (rst)
        job.start |=> !err); // R7

    AST_ERR_SET_ON_NACK: assert property (@(posedge clk) disable iff (rst)
        evt.ack_err |=> err); // R6

    AST_NACK_GOES_TO_STOP: assert property (@(posedge clk) disable iff (rst)
        evt.ack_err |-> (phase == PH_STOP)); // R8

    AST_SECOND_BYTE_ONLY_LONG: assert property (@(posedge clk) disable iff (rst)
        (evt.rx_valid && evt.rx_idx) |-> job.two); // R9

    AST_SDA_QUIET_SCL_HIGH: assert property (@(posedge clk) disable iff (rst)
        (!scl_oe && !$past(scl_oe) && phase != PH_START && phase != PH_STOP)
            |-> $stable(sda_oe)); // R11

endmodule

bind i2cm_top i2cm_chk chk_i (
    .clk    (clk),
    .rst    (rst),
    .phase  (phase),
    .evt    (evt),
    .job    (job),
    .busy   (busy),
    .err    (err),
    .scl_oe (scl_oe),
    .sda_oe (sda_oe)
);

// File: tb/i2cm_top_tb_top.sv
`timescale 1ns/1ps
module i2cm_top_tb_top;
    localparam int Q = 3;
    localparam logic [6:0] SLV = 7'h2A;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic reg_wr = 1'b0;
    logic [2:0] reg_addr = 3'd0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic scl_oe, sda_oe;
    logic s_pull = 1'b0;
    logic scl, sda;

    always #2.5 clk = ~clk;

    assign scl = !scl_oe;
    assign sda = !(sda_oe || s_pull);

    i2cm_top #(.QTR_CYCLES(Q)) dut_i (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .scl_oe(scl_oe), .sda_in(sda), .sda_oe(sda_oe)
    );

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // ---------------- slave bus model (runs on falling clock edge) ----------
    logic       scl_d = 1'b1, sda_d = 1'b1;
    int         s_st = 0;      // 0 idle, 1 address, 2 write, 3 read
    int         s_bit = -1;
    int         s_bidx = 0;
    logic [7:0] s_sh = 8'h00;
    logic       s_ack_now = 1'b0;
    logic [7:0] s_rx [2];
    int         s_nrx = 0;
    logic       s_mack [2];
    int         s_nmack = 0;
    int         s_starts = 0, s_stops = 0;
    logic [7:0] s_tx0 = 8'h00, s_tx1 = 8'h00;
    int         s_nack_at = 0;
    longint     cyc = 0;
    longint     rise_prev = -1;
    longint     period = 0;

    function automatic logic [7:0] txb(input int i);
        return (i == 0) ? s_tx0 : s_tx1;
    endfunction

    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            if (scl && scl_d && sda_d && !sda) begin
                s_starts++; s_st = 1; s_bit = -1; s_sh = 8'h00; s_bidx = 0; s_pull = 1'b0;
            end else if (scl && scl_d && !sda_d && sda) begin
                s_stops++; s_st = 0; s_pull = 1'b0;
            end else if (scl && !scl_d) begin
                if (rise_prev >= 0) period = cyc - rise_prev;
                rise_prev = cyc;
                if (s_bit >= 0 && s_bit < 8 && (s_st == 1 || s_st == 2)) s_sh = {s_sh[6:0], sda};
                else if (s_bit == 8 && s_st == 3) begin
                    if (s_nmack < 2) s_mack[s_nmack] = sda;
                    s_nmack++;
                    if (sda) s_st = 0;
                end
            end else if (!scl && scl_d && s_st != 0) begin
                if (s_bit == 8) begin
                    s_bit = 0; s_pull = 1'b0;
                    if (s_st == 1) s_st = s_ack_now ? (s_sh[0] ? 3 : 2) : 0;
                    else if (s_st == 2) begin if (!s_ack_now) s_st = 0; s_bidx++; end
                    else if (s_st == 3) s_bidx++;
                    if (s_st == 3) s_pull = !txb(s_bidx)[7];
                end else begin
                    s_bit++;
                    if (s_bit == 8) begin
                        if (s_st == 1) begin
                            s_ack_now = (s_sh[7:1] == SLV); s_pull = s_ack_now;
                        end else if (s_st == 2) begin
                            if (s_nrx < 2) s_rx[s_nrx] = s_sh;
                            s_nrx++;
                            s_ack_now = (s_nack_at != s_bidx + 1); s_pull = s_ack_now;
                        end else s_pull = 1'b0;
                    end else if (s_st == 3 && s_bit > 0) s_pull = !txb(s_bidx)[7 - s_bit];
                end
            end
        end
        scl_d = scl; sda_d = sda;
    end

    // ---------------- register access ----------------
    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk); reg_addr = a; #1 d = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [7:0] c;
        for (int i = 0; i < 20000; i++) begin
            rd(3'd5, c);
            if (!c[1]) return;
        end
    endtask

    task automatic launch(input logic [7:0] tgt, input logic two, input logic [7:0] w0,
                          input logic [7:0] w1, input logic [7:0] t0, input logic [7:0] t1,
                          input int nack_at);
        s_tx0 = t0; s_tx1 = t1; s_nack_at = nack_at;
        s_nrx = 0; s_nmack = 0; s_starts = 0; s_stops = 0;
        wr(3'd0, tgt); wr(3'd1, w0); wr(3'd2, w1);
        wr(3'd5, {6'b0, 1'b1, two});
    endtask

    typedef struct packed {
        logic [7:0] tgt;
        logic       two;
        logic [7:0] wd0;
        logic [7:0] wd1;
        logic [7:0] tx0;
        logic [7:0] tx1;
        logic [1:0] nack_at;
        logic       exp_err;
        logic [1:0] exp_nb;
        logic [7:0] exp_rd0;
        logic [7:0] exp_rd1;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{8'h54, 1'b0, 8'hA5, 8'h00, 8'h00, 8'h00, 2'd0, 1'b0, 2'd1, 8'h00, 8'h00},
        '{8'h54, 1'b1, 8'h3C, 8'hC3, 8'h00, 8'h00, 2'd0, 1'b0, 2'd2, 8'h00, 8'h00},
        '{8'h55, 1'b0, 8'h00, 8'h00, 8'h96, 8'h00, 2'd0, 1'b0, 2'd1, 8'h96, 8'h00},
        '{8'h55, 1'b1, 8'h00, 8'h00, 8'h5A, 8'hE1, 2'd0, 1'b0, 2'd2, 8'h5A, 8'hE1},
        '{8'h22, 1'b1, 8'h11, 8'h22, 8'h00, 8'h00, 2'd0, 1'b1, 2'd0, 8'h5A, 8'hE1},
        '{8'h54, 1'b1, 8'h77, 8'h88, 8'h00, 8'h00, 2'd1, 1'b1, 2'd1, 8'h5A, 8'hE1},
        '{8'h23, 1'b0, 8'h00, 8'h00, 8'hFF, 8'h00, 2'd0, 1'b1, 2'd0, 8'h5A, 8'hE1},
        '{8'h55, 1'b0, 8'h00, 8'h00, 8'h0F, 8'hAB, 2'd0, 1'b0, 2'd1, 8'h0F, 8'hE1}
    };

    logic done_flag = 1'b0;

    initial begin
        logic [7:0] v;
        repeat (4) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1 / R12: reset state
        for (int a = 0; a < 6; a++) begin
            rd(3'(a), v);
            chk("R1 reset register value", v, 0);
        end
        chk("R12 scl released after reset", scl_oe, 0);
        chk("R12 sda released after reset", sda_oe, 0);

        // table of transfers
        for (int i = 0; i < NV; i++) begin
            vec_t t;
            int nb;
            t = VECS[i];
            nb = t.exp_nb;
            launch(t.tgt, t.two, t.wd0, t.wd1, t.tx0, t.tx1, t.nack_at);
            rd(3'd5, v);
            chk("R2 busy reads 1 after launch", v[1], 1);
            chk("R7 error flag clear after launch", v[2], 0);
            chk("R4 length bit readback", v[0], t.two);
            wait_idle();
            rd(3'd5, v);
            chk("R2 busy clears after STOP", v[1], 0);
            chk("R6 ack error flag", v[2], t.exp_err);
            chk("R8 one START per transfer", s_starts, 1);
            chk("R8 one STOP per transfer", s_stops, 1);
            if (!t.tgt[0]) begin
                chk("R4 bytes seen by slave", s_nrx, nb);
                for (int k = 0; k < nb; k++)
                    chk("R5 write byte order", s_rx[k], (k == 0) ? t.wd0 : t.wd1);
            end else begin
                chk("R4 bytes read by master", s_nmack, nb);
                for (int k = 0; k < nb; k++)
                    chk("R10 master ack level", s_mack[k], (k == nb - 1) ? 1 : 0);
                rd(3'd3, v); chk("R9 first read byte", v, t.exp_rd0);
                rd(3'd4, v); chk("R9 second read byte", v, t.exp_rd1);
            end
        end

        // R11: SCL period
        chk("R11 SCL period in clocks", int'(period), 4 * Q);

        // R3: writes during busy are discarded
        launch(8'h54, 1'b1, 8'h12, 8'h34, 8'h00, 8'h00, 0);
        wr(3'd0, 8'hFF); wr(3'd1, 8'h00); wr(3'd2, 8'h00); wr(3'd5, 8'h00);
        rd(3'd5, v);
        chk("R3 control write ignored while busy", v[1:0], 2'b11);
        wait_idle();
        rd(3'd0, v); chk("R3 target kept", v, 8'h54);
        rd(3'd1, v); chk("R3 data 0 kept", v, 8'h12);
        rd(3'd2, v); chk("R3 data 1 kept", v, 8'h34);
        chk("R3 bus carried original bytes", s_nrx, 2);
        chk("R3 bus byte 1", s_rx[1], 8'h34);
        chk("R12 bus released at end", {scl_oe, sda_oe}, 0);

        done_flag = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule